// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port

This block is a cut-down boundary-scan test access port. It is clocked by a test clock. A mode-select input steers a sixteen-state controller through capture, shift and update phases for an instruction path and a data path. Serial data enters on a data input and leaves on a tri-state data output. An active-low asynchronous reset input is also provided. A 3-bit instruction picks one of three data registers. The first is a fixed 32-bit identification word. The second is a single-bit bypass stage. The third is a short boundary register that can only sample a set of pin values.

The block implements only part of the usual function set. The boundary register has no preload or update stage, so it never drives anything. Passing through Update-DR while the boundary register is selected has the same effect as pausing. The instruction returns to the identification code at power-up and each time the controller enters Test-Logic-Reset. The port is used to read the identification word, to snapshot pin states, or to pass serial data through with one bit of delay.

Top module: `scan_port`

## Requirements
- R1: Five consecutive rising test-clock edges with the mode input high bring the controller to Test-Logic-Reset from any state. That state restores the identification instruction (code 001).
- R2: A low level on `trstN` immediately forces Test-Logic-Reset, the identification instruction, and a high-impedance `tdo`.
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR moves it out on `tdo` least significant bit first, with `tdi` entering at the most significant bit. The new code takes effect at Update-IR.
- R4: Under code 001, Capture-DR loads the 32-bit identification word and Shift-DR moves it out LSB first. Bit 0 of the word is 1, bits 31:29 hold the revision parameter, and bits 28:1 hold the body parameter.
- R5: Code 111 and the unused codes 011, 100, 101 and 110 select the bypass bit. This bit captures 0 and delays `tdi` by exactly one shift.
- R6: Codes 010 (sample) and 000 (external test) select the boundary register. Capture-DR loads `pinSample`, and the register shifts out LSB first.
- R7: Update-DR under code 010 or 000 has no effect. Whether Update-DR is reached directly or through Pause-DR, the next data scan returns the freshly captured pins and not the bits shifted in before.
- R8: `tdo` changes only on falling test-clock edges. It is driven during Shift-IR and Shift-DR and is high-impedance in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pinSample | input | BSR_LEN | Pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, high-impedance outside shift states |

## Verification
The last shift and the exit from a shift state happen on the same rising edge. When `tms` goes high in Shift-IR or Shift-DR, the final `tdi` bit must still enter the register while the controller moves to Exit1. The bench provokes this on every scan by raising `tms` with the final bit, and judges it through the instruction that takes effect or the data that follows. A second collision is an asynchronous reset that arrives in the middle of a data shift. The bench checks that `tdo` floats at once and that the next scan returns the identification word.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PAUDR, ST_EX2DR, ST_UPDDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PAUIR, ST_EX2IR, ST_UPDIR
  } tapState_e;

  typedef enum logic [1:0] { PATH_ID, PATH_BYP, PATH_BSR } drPath_e;

  typedef struct packed {
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic rstIr;
    logic shiftOn;
  } tapStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  tapState,
  output tapStrobe_t strobe
);
  tapState_e nextState;

  always_comb begin
    nextState = tapState;
    unique case (tapState)
      ST_RESET: nextState = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: nextState = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nextState = tms ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: nextState = tms ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: nextState = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: nextState = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: nextState = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nextState = tms ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: nextState = tms ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: nextState = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: nextState = tms ? ST_SELDR : ST_IDLE;
      default:  nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= ST_RESET;
    else        tapState <= nextState;
  end

  always_comb begin
    strobe.capIr   = (tapState == ST_CAPIR);
    strobe.shIr    = (tapState == ST_SHIR);
    strobe.updIr   = (tapState == ST_UPDIR);
    strobe.capDr   = (tapState == ST_CAPDR);
    strobe.shDr    = (tapState == ST_SHDR);
    strobe.rstIr   = (tapState == ST_RESET);
    strobe.shiftOn = (tapState == ST_SHIR) || (tapState == ST_SHDR);
  end
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [2:0]  REV_NUM = 3'b010,
  parameter logic [27:0] ID_BODY = 28'h1A2B3C4
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdoQ,
  output logic               tdoOe,
  output logic [IR_W-1:0]    irCode,
  output logic [IR_W-1:0]    irSh,
  output logic               byQ,
  output drPath_e            path
);
  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {REV_NUM, ID_BODY, 1'b1};

  logic [ID_W-1:0]    idSh;
  logic [BSR_LEN-1:0] bsrSh;
  logic [BSR_LEN-1:0] bsrNext;
  logic               drBit;

  always_comb begin
    unique case (irCode)
      OP_IDCODE:            path = PATH_ID;
      OP_SAMPLE, OP_EXTEST: path = PATH_BSR;
      default:              path = PATH_BYP;
    endcase
  end

  generate
    if (BSR_LEN == 1) begin : g_bsrOne
      assign bsrNext = tdi;
    end else begin : g_bsrMany
      assign bsrNext = {tdi, bsrSh[BSR_LEN-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irSh  <= '0;
      idSh  <= '0;
      bsrSh <= '0;
      byQ   <= 1'b0;
    end else begin
      if (strobe.capIr)     irSh <= IR_CAPTURE;
      else if (strobe.shIr) irSh <= {tdi, irSh[IR_W-1:1]};

      unique case (path)
        PATH_ID: begin
          if (strobe.capDr)     idSh <= ID_WORD;
          else if (strobe.shDr) idSh <= {tdi, idSh[ID_W-1:1]};
        end
        PATH_BSR: begin
          if (strobe.capDr)     bsrSh <= pinSample;
          else if (strobe.shDr) bsrSh <= bsrNext;
        end
        default: begin
          if (strobe.capDr)     byQ <= 1'b0;
          else if (strobe.shDr) byQ <= tdi;
        end
      endcase
    end
  end

  always_comb begin
    unique case (path)
      PATH_ID:  drBit = idSh[0];
      PATH_BSR: drBit = bsrSh[0];
      default:  drBit = byQ;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      irCode <= OP_IDCODE;
      tdoQ   <= 1'b0;
      tdoOe  <= 1'b0;
    end else begin
      if (strobe.rstIr)      irCode <= OP_IDCODE;
      else if (strobe.updIr) irCode <= irSh;
      tdoOe <= strobe.shiftOn;
      tdoQ  <= strobe.shIr ? irSh[0] : drBit;
    end
  end
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [2:0]  REV_NUM = 3'b010,
  parameter logic [27:0] ID_BODY = 28'h1A2B3C4
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdo
);
  tapState_e       tapState;
  tapStrobe_t      strobe;
  logic            tdoQ;
  logic            tdoOe;
  logic [IR_W-1:0] irCode;
  logic [IR_W-1:0] irSh;
  logic            byQ;
  drPath_e         path;

  scan_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms),
    .tapState(tapState), .strobe(strobe)
  );

  scan_dp #(.BSR_LEN(BSR_LEN), .REV_NUM(REV_NUM), .ID_BODY(ID_BODY)) u_dp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobe(strobe),
    .pinSample(pinSample), .tdoQ(tdoQ), .tdoOe(tdoOe),
    .irCode(irCode), .irSh(irSh), .byQ(byQ), .path(path)
  );

  assign tdo = tdoOe ? tdoQ : 1'bz;
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input tapState_e       tapState,
  input logic [IR_W-1:0] irCode,
  input logic [IR_W-1:0] irSh,
  input logic            byQ,
  input logic            tdoOe,
  input drPath_e         path
);
  logic [2:0] highRun;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)       highRun <= 3'd0;
    else if (!tms)    highRun <= 3'd0;
    else if (highRun != 3'd5) highRun <= highRun + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!trstN)
    (highRun == 3'd5) |-> (tapState == ST_RESET));

  // R1
  reset_ir_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_RESET) |-> (irCode == OP_IDCODE));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_CAPIR) |=> (irSh == IR_CAPTURE));

  // R5
  bypass_capture_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_CAPDR && path == PATH_BYP) |=> (byQ == 1'b0));

  // R8
  tdo_float_chk: assert property (@(posedge tck) disable iff (!trstN)
    (tapState != ST_SHDR && tapState != ST_SHIR) |-> !tdoOe);
endmodule

bind scan_port scan_port_chk chk (
  .tck(tck), .trstN(trstN), .tms(tms), .tapState(tapState),
  .irCode(irCode), .irSh(irSh), .byQ(byQ), .tdoOe(tdoOe), .path(path)
);

// File: tb/scan_port_test.sv
module scan_port_test;
  localparam int          BL   = 8;
  localparam logic [2:0]  REV  = 3'b010;
  localparam logic [27:0] BODY = 28'h1A2B3C4;
  localparam logic [31:0] EXP_ID = {REV, BODY, 1'b1};

  // each entry: {instruction code, pin values, tdi pattern}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {3'b001, 8'h00, 8'h00},
    {3'b111, 8'h00, 8'hC3},
    {3'b010, 8'hA5, 8'h3C},
    {3'b000, 8'h5A, 8'hFF},
    {3'b011, 8'h00, 8'h96},
    {3'b100, 8'h00, 8'h81},
    {3'b101, 8'h00, 8'h7E},
    {3'b110, 8'hFF, 8'h35}
  };

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic [BL-1:0] pinSample = '0;
  wire  tdo;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit edgeViol = 0;

  scan_port #(.BSR_LEN(BL), .REV_NUM(REV), .ID_BODY(BODY)) uut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .pinSample(pinSample), .tdo(tdo)
  );

  always #2 tck = ~tck;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic tick(input logic m, input logic d);
    logic pre;
    tms = m;
    tdi = d;
    pre = tdo;
    @(posedge tck);
    #1;
    if (tdo !== pre) edgeViol = 1;
    @(negedge tck);
    #1;
  endtask

  task automatic scanIr(input logic [2:0] code, output logic [2:0] got);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      got[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [31:0] din, input bit viaPause,
                        output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    if (viaPause) begin
      tick(0, 0); tick(1, 0); tick(1, 0);
    end else begin
      tick(1, 0);
    end
    tick(0, 0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    logic [31:0] got;
    logic [2:0]  irGot;
    logic [31:0] exp;
    int          len;

    #5;
    // R2: reset state floats tdo
    chk("R2 tdo floats in reset", {31'd0, tdo === 1'bz}, 32'd1);
    @(negedge tck); #1;
    trstN = 1'b1;
    tick(0, 0);
    // R8: idle keeps tdo released
    chk("R8 tdo floats in idle", {31'd0, tdo === 1'bz}, 32'd1);
    // R2 / R4: identification word after reset
    scanDr(32, 32'h0, 0, got);
    chk("R2 R4 idcode after reset", got, EXP_ID);
    chk("R4 bit0 one", {31'd0, got[0]}, 32'd1);
    chk("R4 revision field", {29'd0, got[31:29]}, {29'd0, REV});

    // R3 R4 R5 R6: table of instructions
    for (int v = 0; v < NV; v++) begin
      logic [2:0] code;
      logic [7:0] pins;
      logic [7:0] pat;
      code = VEC[v][18:16];
      pins = VEC[v][15:8];
      pat  = VEC[v][7:0];
      pinSample = pins;
      scanIr(code, irGot);
      chk("R3 ir capture pattern", {29'd0, irGot}, 32'd1);
      if (code == 3'b001) begin
        len = 32; exp = EXP_ID;
      end else if (code == 3'b010 || code == 3'b000) begin
        len = 8; exp = {24'd0, pins};
      end else begin
        len = 8; exp = {24'd0, pat[6:0], 1'b0};
      end
      scanDr(len, {24'd0, pat}, 0, got);
      if (code == 3'b001)      chk("R4 idcode scan", got, exp);
      else if (len == 8 && (code == 3'b010 || code == 3'b000))
                               chk("R6 boundary capture", got, exp);
      else                     chk("R5 bypass delay", got, exp);
    end

    // R1: five high edges from Shift-DR under bypass
    scanIr(3'b111, irGot);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    scanDr(32, 32'h0, 0, got);
    chk("R1 reset from shift-dr", got, EXP_ID);

    // R1: five high edges from Shift-IR
    scanIr(3'b111, irGot);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    scanDr(32, 32'h0, 0, got);
    chk("R1 reset from shift-ir", got, EXP_ID);

    // R2: asynchronous reset in the middle of a shift
    scanIr(3'b111, irGot);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    chk("R8 tdo driven in shift", {31'd0, tdo === 1'bz}, 32'd0);
    trstN = 1'b0;
    #1;
    chk("R2 tdo floats at once", {31'd0, tdo === 1'bz}, 32'd1);
    @(negedge tck); #1;
    trstN = 1'b1;
    tick(0, 0);
    scanDr(32, 32'h0, 0, got);
    chk("R2 idcode after async reset", got, EXP_ID);

    // R7: update-dr under sample, direct and via pause
    scanIr(3'b010, irGot);
    pinSample = 8'hA5;
    scanDr(8, 32'h3C, 1, got);
    chk("R7 sample first scan", got, 32'hA5);
    pinSample = 8'h0F;
    scanDr(8, 32'hC3, 0, got);
    chk("R7 sample ignores update", got, 32'h0F);
    scanIr(3'b000, irGot);
    pinSample = 8'h66;
    scanDr(8, 32'h99, 0, got);
    pinSample = 8'h81;
    scanDr(8, 32'h00, 1, got);
    chk("R7 extest ignores update", got, 32'h81);

    // R8: tdo never moved on a rising edge
    chk("R8 tdo only on falling edge", {31'd0, edgeViol}, 32'd0);

    finish();
  end
endmodule